// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the memory address of an operand for a small register machine, and it produces the new value of the base register when the addressing mode changes that register. Each request gives the block a mode code, the current base register contents, a signed 16-bit displacement taken from the instruction and an unsigned access-size step. One clock later the block returns the address to use, the value to write back into the base register, a write-back strobe and an error flag for mode codes that have no meaning.

There are four modes. The first passes the register through as the address. The second adds the displacement to the register. The third uses the register unchanged for the access and then raises it by the step, which is how a stack pop works. The fourth lowers the register by the step first and uses that lowered value for the access, which is how a stack push works. With a step of 4, a word push moves the pointer down by 4 and a word pop moves it up by 4. The sequencer that calls the block writes `wb_data` into the register file when `wb_en` is high. The register file, the memory port and the instruction decode are not part of this block.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode code 0 (register indirect): `ea` equals `base_in`, `wb_data` equals `base_in`, and `wb_en` stays low.
- R2: Mode code 1 (indexed): `ea` equals `base_in` plus `disp` sign-extended from 16 to 32 bits as a two's-complement value. `wb_data` equals `base_in` and `wb_en` stays low.
- R3: Mode code 2 (post-increment): `ea` equals the unchanged `base_in`, and `wb_data` equals `base_in` plus `step`, with `step` zero-extended.
- R4: Mode code 3 (pre-decrement): `wb_data` equals `base_in` minus the zero-extended `step`, and `ea` equals that same reduced value.
- R5: `wb_en` is high for exactly the one cycle in which `res_valid` reports a mode 2 or mode 3 request. It is low in every other cycle.
- R6: All address arithmetic wraps modulo 2^32 with no overflow indication. For example, base 0xFFFFFFFC plus step 4 gives 0, and base 0 minus step 4 gives 0xFFFFFFFC.
- R7: Mode codes 4 to 7 are undefined. When one of them arrives, `bad_mode` is high in the result cycle, `wb_en` is low, and `ea` and `wb_data` both equal `base_in`.
- R8: The results appear on the first rising edge after a request taken with `req_valid` high. `res_valid` follows `req_valid` with one cycle of delay. `wb_en` and `bad_mode` are low while `res_valid` is low, and all three are low during and after reset until a request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Addressing mode code (0 to 3 defined) |
| base_in | input | 32 | Current base register contents |
| disp | input | 16 | Signed displacement for indexed mode |
| step | input | 8 | Unsigned access size for the auto modes |
| res_valid | output | 1 | Result registers hold a new result |
| ea | output | 32 | Effective address |
| wb_data | output | 32 | Updated base register value |
| wb_en | output | 1 | Write `wb_data` back to the base register |
| bad_mode | output | 1 | The request used an undefined mode code |

## Verification
All eight mode codes are swept against a set of base values, displacements and steps. The base values include zero, small values, values next to the sign boundary and values next to the top of the address space. The displacements include zero, ±1 and both 16-bit extremes, which shows whether sign extension is correct and whether the offset reaches the indirect or auto modes when it should not. Steps of 1, 2 and 4 show whether post-increment and pre-decrement use the old or the new value for the address. The bases near 0 and 0xFFFFFFFF check the wrap in both directions. Requests are issued back to back and with idle gaps, so the bench can check that the write-back strobe lasts exactly one cycle and does not follow the bus once the request ends.

// File: rtl/eau_pkg.sv
`timescale 1ns/1ps
package eau_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      AM_IND  = 3'd0,
      AM_IDX  = 3'd1,
      AM_POST = 3'd2,
      AM_PRE  = 3'd3
   } am_e;

   typedef struct packed {
      logic idx;
      logic inc;
      logic dec;
      logic wb;
      logic err;
   } am_ctl_t;

endpackage

// File: rtl/eau_decode.sv
`timescale 1ns/1ps
module eau_decode
   import eau_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   output am_ctl_t           ctl
);
   always_comb begin
      ctl = '0;
      unique case (mode)
         AM_IND:  ctl = '0;
         AM_IDX:  ctl.idx = 1'b1;
         AM_POST: begin
            ctl.inc = 1'b1;
            ctl.wb  = 1'b1;
         end
         AM_PRE: begin
            ctl.dec = 1'b1;
            ctl.wb  = 1'b1;
         end
         default: ctl.err = 1'b1;
      endcase
   end
endmodule

// File: rtl/eau_datapath.sv
`timescale 1ns/1ps
module eau_datapath
   import eau_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int OFS_W        = 16,
   parameter int STEP_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [STEP_W-1:0] stp,
   input  am_ctl_t           ctl,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] base_nxt
);
   localparam int OFS_PAD  = ADDR_W - OFS_W;
   localparam int STEP_PAD = ADDR_W - STEP_W;

   logic [ADDR_W-1:0] ofs_x;
   logic [ADDR_W-1:0] step_x;

   assign ofs_x  = {{OFS_PAD{ofs[OFS_W-1]}}, ofs};
   assign step_x = {{STEP_PAD{1'b0}}, stp};

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [ADDR_W-1:0] addend;
         logic [ADDR_W-1:0] sum;
         always_comb begin
            if (ctl.idx)      addend = ofs_x;
            else if (ctl.inc) addend = step_x;
            else if (ctl.dec) addend = -step_x;
            else              addend = '0;
         end
         assign sum      = base + addend;
         assign addr     = (ctl.idx | ctl.dec) ? sum : base;
         assign base_nxt = (ctl.inc | ctl.dec) ? sum : base;
      end else begin : g_split
         logic [ADDR_W-1:0] idx_sum;
         logic [ADDR_W-1:0] upd;
         assign idx_sum  = base + ofs_x;
         assign upd      = ctl.dec ? (base - step_x) : (base + step_x);
         assign addr     = ctl.idx ? idx_sum : (ctl.dec ? upd : base);
         assign base_nxt = (ctl.inc | ctl.dec) ? upd : base;
      end
   endgenerate
endmodule

// File: rtl/eau_outreg.sv
`timescale 1ns/1ps
module eau_outreg
   import eau_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v_in,
   input  am_ctl_t           ctl,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [ADDR_W-1:0] base_d,
   output logic              v_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] base_q,
   output logic              wb_q,
   output logic              err_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         wb_q   <= 1'b0;
         err_q  <= 1'b0;
         addr_q <= '0;
         base_q <= '0;
      end else begin
         v_q   <= v_in;
         wb_q  <= v_in & ctl.wb;
         err_q <= v_in & ctl.err;
         if (v_in) begin
            addr_q <= addr_d;
            base_q <= base_d;
         end
      end
   end
endmodule

// File: rtl/eff_addr_unit.sv
`timescale 1ns/1ps
module eff_addr_unit
   import eau_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int OFS_W        = 16,
   parameter int STEP_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        mode,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [OFS_W-1:0]  disp,
   input  logic [STEP_W-1:0] step,
   output logic              res_valid,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] wb_data,
   output logic              wb_en,
   output logic              bad_mode
);
   generate
      if (OFS_W > ADDR_W) begin : g_bad_ofs
         $error("eff_addr_unit: OFS_W must not exceed ADDR_W");
      end
      if (STEP_W >= ADDR_W) begin : g_bad_step
         $error("eff_addr_unit: STEP_W must be below ADDR_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("eff_addr_unit: ADDR_W must be at least 8");
      end
   endgenerate

   am_ctl_t           ctl;
   logic [ADDR_W-1:0] addr_c;
   logic [ADDR_W-1:0] base_c;

   eau_decode u_dec (
      .mode (mode),
      .ctl  (ctl)
   );

   eau_datapath #(
      .ADDR_W       (ADDR_W),
      .OFS_W        (OFS_W),
      .STEP_W       (STEP_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_dp (
      .base     (base_in),
      .ofs      (disp),
      .stp      (step),
      .ctl      (ctl),
      .addr     (addr_c),
      .base_nxt (base_c)
   );

   eau_outreg #(
      .ADDR_W (ADDR_W)
   ) u_oreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_in   (req_valid),
      .ctl    (ctl),
      .addr_d (addr_c),
      .base_d (base_c),
      .v_q    (res_valid),
      .addr_q (ea),
      .base_q (wb_data),
      .wb_q   (wb_en),
      .err_q  (bad_mode)
   );
endmodule

// File: rtl/eau_chk.sv
`timescale 1ns/1ps
module eau_chk #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 16,
   parameter int STEP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        mode,
   input logic [ADDR_W-1:0] base_in,
   input logic [OFS_W-1:0]  disp,
   input logic [STEP_W-1:0] step,
   input logic              res_valid,
   input logic [ADDR_W-1:0] ea,
   input logic [ADDR_W-1:0] wb_data,
   input logic              wb_en,
   input logic              bad_mode
);
   // R5
   wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> res_valid);

   // R7
   err_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_mode |-> !wb_en);

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!res_valid && !wb_en && !bad_mode));

   // R3
   post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 3'd2) |=>
         (ea == $past(base_in) && wb_en &&
          wb_data == $past(base_in) + ADDR_W'($past(step))));

   // R4
   pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 3'd3) |=>
         (ea == wb_data && wb_en &&
          wb_data == $past(base_in) - ADDR_W'($past(step))));

   // R1
   indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 3'd0) |=>
         (ea == $past(base_in) && !wb_en && !bad_mode));

   // R2
   indexed_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == 3'd1) |=> (!wb_en && wb_data == $past(base_in)));

   // R7
   undef_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode[2]) |=> (bad_mode && ea == $past(base_in)));
endmodule

bind eff_addr_unit eau_chk #(
   .ADDR_W (ADDR_W),
   .OFS_W  (OFS_W),
   .STEP_W (STEP_W)
) u_chk (.*);

// File: tb/sim_eff_addr_unit.sv
`timescale 1ns/1ps
module sim_eff_addr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [31:0] base_in = '0;
   logic [15:0] disp = '0;
   logic [7:0]  step = '0;
   logic        res_valid;
   logic [31:0] ea;
   logic [31:0] wb_data;
   logic        wb_en;
   logic        bad_mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   eff_addr_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .mode      (mode),
      .base_in   (base_in),
      .disp      (disp),
      .step      (step),
      .res_valid (res_valid),
      .ea        (ea),
      .wb_data   (wb_data),
      .wb_en     (wb_en),
      .bad_mode  (bad_mode)
   );

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'd0:    return "R1";
         3'd1:    return "R2";
         3'd2:    return "R3";
         3'd3:    return "R4";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act_a,
                        input logic [31:0] act_b, input logic [3:0] act_f,
                        input logic [31:0] exp_a, input logic [31:0] exp_b,
                        input logic [3:0] exp_f);
      checks++;
      if (act_a !== exp_a || act_b !== exp_b || act_f !== exp_f) begin
         errors++;
         $display("FAIL %s: ea/wb_data/flags actual %h %h %b expected %h %h %b",
                  req, act_a, act_b, act_f, exp_a, exp_b, exp_f);
      end
   endtask

   // drive one request at a falling edge, check its result one clock later
   task automatic one_op(input logic [2:0] m, input logic [31:0] b,
                         input logic [15:0] d, input logic [7:0] s,
                         input string tag);
      logic [31:0] ex_a, ex_b;
      logic        ex_wb, ex_err;
      logic [31:0] dx, sx;
      dx = {{16{d[15]}}, d};
      sx = {24'd0, s};
      ex_a = b; ex_b = b; ex_wb = 1'b0; ex_err = 1'b0;
      case (m)
         3'd0: ;
         3'd1: ex_a = b + dx;
         3'd2: begin ex_b = b + sx; ex_wb = 1'b1; end
         3'd3: begin ex_b = b - sx; ex_a = b - sx; ex_wb = 1'b1; end
         default: ex_err = 1'b1;
      endcase
      req_valid = 1'b1; mode = m; base_in = b; disp = d; step = s;
      @(negedge clk);
      check(tag, ea, wb_data, {res_valid, wb_en, bad_mode, 1'b0},
            ex_a, ex_b, {1'b1, ex_wb, ex_err, 1'b0});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] bases [6];
      logic [15:0] offs  [6];
      logic [7:0]  steps [3];
      bases = '{32'h0, 32'h4, 32'h7FFF_FFFC, 32'hFFFF_FFFC, 32'h1234_5678, 32'h2};
      offs  = '{16'h0, 16'h1, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h000C};
      steps = '{8'd1, 8'd2, 8'd4};

      // R8: reset state
      repeat (2) @(negedge clk);
      check("R8", 32'h0, 32'h0, {res_valid, wb_en, bad_mode, 1'b0},
            32'h0, 32'h0, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", 32'h0, 32'h0, {res_valid, wb_en, bad_mode, 1'b0},
            32'h0, 32'h0, 4'b0000);

      // sweep, back to back
      for (int m = 0; m < 8; m++)
         for (int bi = 0; bi < 6; bi++)
            for (int oi = 0; oi < 6; oi++)
               for (int si = 0; si < 3; si++)
                  one_op(3'(m), bases[bi], offs[oi], steps[si], req_of(3'(m)));

      // R6: wrap in both directions
      one_op(3'd2, 32'hFFFF_FFFC, 16'h0, 8'd4, "R6");
      check("R6", ea, wb_data, 4'b0, 32'hFFFF_FFFC, 32'h0, 4'b0);
      one_op(3'd3, 32'h0, 16'h0, 8'd4, "R6");
      check("R6", ea, wb_data, 4'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 4'b0);
      one_op(3'd1, 32'hFFFF_FFFF, 16'h0002, 8'd0, "R6");
      check("R6", ea, 32'h0, 4'b0, 32'h1, 32'h0, 4'b0);

      // R5: strobe lasts one cycle, then idle
      one_op(3'd3, 32'h100, 16'h0, 8'd4, "R5");
      req_valid = 1'b0;
      @(negedge clk);
      check("R5", 32'h0, 32'h0, {res_valid, wb_en, bad_mode, 1'b0},
            32'h0, 32'h0, 4'b0000);
      // R8: idle cycle after an undefined mode clears the error flag
      one_op(3'd6, 32'h55, 16'h0, 8'd4, "R7");
      req_valid = 1'b0;
      @(negedge clk);
      check("R8", 32'h0, 32'h0, {res_valid, wb_en, bad_mode, 1'b0},
            32'h0, 32'h0, 4'b0000);

      // R3 and R4 as a push/pop pair with word step
      one_op(3'd3, 32'h0000_1000, 16'h0, 8'd4, "R4");
      check("R4", ea, 32'h0, 4'b0, 32'h0000_0FFC, 32'h0, 4'b0);
      one_op(3'd2, 32'h0000_0FFC, 16'h0, 8'd4, "R3");
      check("R3", ea, wb_data, 4'b0, 32'h0000_0FFC, 32'h0000_1000, 4'b0);
      req_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule